// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block watches the bytes of each received Ethernet frame for a wake-on-LAN magic sequence. The sequence starts with a run of six 0xFF sync bytes. Any number of other bytes may follow the sync. After them comes the station's 6-byte ID, sent sixteen times back to back. The sequence may sit at any offset inside the frame.

A completed sequence is held in a per-frame latch. It turns into a wake event only if the frame's end-of-frame beat reports a good frame, and only if both the magic-enable bit and the power-management-enable bit are set. Frames with a CRC error, or frames that arrive while either enable is clear, produce nothing.

The block sits beside the receive MAC and takes the MAC's byte stream. It gives a single-cycle wake pulse that power-management logic can latch.

Top module: `mpkt_wake_det`

## Requirements
- R1: A sync is six consecutive valid bytes equal to 0xFF. Any other byte inside the run restarts the count, and five 0xFF bytes followed by a different byte never arm the search.
- R2: After a sync, the ID bytes are compared in transmission order. ID byte k is station_id_i[8k+7:8k], so byte 0 is bits 7:0 and is sent first. The same six bytes in any other order do not match.
- R3: Any number of bytes may sit between the sync and the first ID repetition, and the whole sequence may start at any offset in the frame. Cycles with byte_vld_i low inside the frame are skipped.
- R4: A byte that breaks an ID run resets the repetition count. If that byte equals ID byte 0, it starts a new run. A run of more than six 0xFF bytes still counts as a sync.
- R5: When frame_ok_i is low on the end-of-frame beat, no wake pulse is produced, even if the frame holds a full sequence.
- R6: magic_en_i and pme_en_i are sampled on the end-of-frame beat. A wake pulse needs both of them high.
- R7: wake_o is high for exactly one cycle: the cycle after the clock edge that takes in the end-of-frame beat.
- R8: The match latch clears on every start-of-frame beat, so a match in one frame never produces a wake pulse for a later frame.
- R9: While reset is asserted, and right after it, wake_o is low.
- R10: A sequence whose last ID byte is also the frame's end-of-frame byte produces a wake pulse.
- R11: Fifteen ID repetitions after a sync are not enough. Such a frame produces no wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_vld_i | input | 1 | A frame byte is present on byte_i |
| sof_i | input | 1 | The current valid byte is the first byte of the frame |
| eof_i | input | 1 | The current valid byte is the last byte of the frame |
| byte_i | input | 8 | Received byte |
| frame_ok_i | input | 1 | The frame had no errors; read on the end-of-frame beat |
| station_id_i | input | 48 | Station ID; byte 0 in bits 7:0 |
| magic_en_i | input | 1 | Magic wake enable |
| pme_en_i | input | 1 | Power-management event enable |
| wake_o | output | 1 | One-cycle wake event pulse |

## Verification
The main function is tried with four kinds of stream.

- Clean sequences at the start of the frame, in the middle, with filler after the sync, with idle gaps, and ending on the last byte. These show that position and gaps do not matter.
- Near misses: a five-byte sync, a broken sync, fifteen repetitions, and the ID sent in reversed byte order. These separate a correct sync count, repetition count and byte order from looser ones.
- A run broken partway, with the breaking byte equal to ID byte 0, and an over-long 0xFF run. These show whether the search resumes correctly.
- Good sequences paired with a bad frame flag, with each enable cleared, and followed by a frame that has no sequence. These separate the gating and the per-frame clearing from the matching itself.

// File: rtl/mpw_pkg.sv
package mpw_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/mpw_sync_finder.sv
module mpw_sync_finder
  import mpw_pkg::*;
#(
  parameter int unsigned SYNC_LEN = 6,
  parameter byte_t       SYNC_VAL = 8'hFF
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  beat_i,
  input  logic  restart_i,
  input  byte_t byte_i,
  output logic  armed_o
);
  localparam int unsigned CW = $clog2(SYNC_LEN + 1);

  logic [CW-1:0] cnt_q, cnt_base, cnt_n;
  logic          armed_q, armed_n;

  always_comb begin
    cnt_base = restart_i ? '0 : cnt_q;
    cnt_n    = cnt_base;
    armed_n  = restart_i ? 1'b0 : armed_q;
    if (beat_i) begin
      if (byte_i == SYNC_VAL) begin
        if (cnt_base != CW'(SYNC_LEN)) cnt_n = cnt_base + 1'b1;
      end else begin
        cnt_n = '0;
      end
      if (cnt_n == CW'(SYNC_LEN)) armed_n = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      armed_q <= armed_n;
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/mpw_id_matcher.sv
module mpw_id_matcher
  import mpw_pkg::*;
#(
  parameter int unsigned ID_BYTES = 6,
  parameter int unsigned REPS     = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       beat_i,
  input  logic                       restart_i,
  input  logic                       armed_i,
  input  byte_t                      byte_i,
  input  logic [BYTE_W*ID_BYTES-1:0] id_i,
  output logic                       hit_o
);
  localparam int unsigned IW = $clog2(ID_BYTES);
  localparam int unsigned RW = $clog2(REPS);

  byte_t         id_b [ID_BYTES];
  logic [IW-1:0] idx_q, idx_base, idx_n;
  logic [RW-1:0] rep_q, rep_base, rep_n;
  logic          armed_eff, last_byte, last_rep;
  byte_t         exp_b;

  for (genvar k = 0; k < ID_BYTES; k++) begin : g_split
    assign id_b[k] = id_i[BYTE_W*k +: BYTE_W];
  end

  // the sync must finish on an earlier byte of the same frame
  assign armed_eff = armed_i & ~restart_i;
  assign idx_base  = restart_i ? '0 : idx_q;
  assign rep_base  = restart_i ? '0 : rep_q;
  assign exp_b     = id_b[idx_base];
  assign last_byte = (idx_base == IW'(ID_BYTES - 1));
  assign last_rep  = (rep_base == RW'(REPS - 1));

  always_comb begin
    idx_n = idx_base;
    rep_n = rep_base;
    hit_o = 1'b0;
    if (beat_i && armed_eff) begin
      if (byte_i == exp_b) begin
        if (last_byte) begin
          idx_n = '0;
          if (last_rep) begin
            hit_o = 1'b1;
            rep_n = '0;
          end else begin
            rep_n = rep_base + 1'b1;
          end
        end else begin
          idx_n = idx_base + 1'b1;
        end
      end else begin
        rep_n = '0;
        idx_n = (byte_i == id_b[0]) ? IW'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      rep_q <= '0;
    end else begin
      idx_q <= idx_n;
      rep_q <= rep_n;
    end
  end
endmodule

// File: rtl/mpw_event_gate.sv
module mpw_event_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic beat_i,
  input  logic restart_i,
  input  logic last_i,
  input  logic ok_i,
  input  logic magic_en_i,
  input  logic pme_en_i,
  input  logic hit_i,
  output logic found_o,
  output logic wake_o
);
  logic found_q, found_n, wake_q, wake_n;

  always_comb begin
    found_n = (restart_i ? 1'b0 : found_q) | (beat_i & hit_i);
    wake_n  = beat_i & last_i & ok_i & magic_en_i & pme_en_i & found_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      found_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      found_q <= found_n;
      wake_q  <= wake_n;
    end
  end

  assign found_o = found_q;
  assign wake_o  = wake_q;
endmodule

// File: rtl/mpkt_wake_det.sv
module mpkt_wake_det
  import mpw_pkg::*;
#(
  parameter int unsigned SYNC_LEN = 6,
  parameter int unsigned ID_BYTES = 6,
  parameter int unsigned REPS     = 16,
  localparam int unsigned ID_W    = BYTE_W * ID_BYTES
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            byte_vld_i,
  input  logic            sof_i,
  input  logic            eof_i,
  input  logic [7:0]      byte_i,
  input  logic            frame_ok_i,
  input  logic [ID_W-1:0] station_id_i,
  input  logic            magic_en_i,
  input  logic            pme_en_i,
  output logic            wake_o
);
  logic restart_w, armed_w, hit_w, found_w;

  assign restart_w = byte_vld_i & sof_i;

  mpw_sync_finder #(
    .SYNC_LEN (SYNC_LEN),
    .SYNC_VAL (8'hFF)
  ) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .beat_i    (byte_vld_i),
    .restart_i (restart_w),
    .byte_i    (byte_i),
    .armed_o   (armed_w)
  );

  mpw_id_matcher #(
    .ID_BYTES (ID_BYTES),
    .REPS     (REPS)
  ) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .beat_i    (byte_vld_i),
    .restart_i (restart_w),
    .armed_i   (armed_w),
    .byte_i    (byte_i),
    .id_i      (station_id_i),
    .hit_o     (hit_w)
  );

  mpw_event_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .beat_i     (byte_vld_i),
    .restart_i  (restart_w),
    .last_i     (eof_i),
    .ok_i       (frame_ok_i),
    .magic_en_i (magic_en_i),
    .pme_en_i   (pme_en_i),
    .hit_i      (hit_w),
    .found_o    (found_w),
    .wake_o     (wake_o)
  );
endmodule

// File: rtl/mpkt_wake_chk.sv
module mpkt_wake_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic byte_vld_i,
  input logic sof_i,
  input logic eof_i,
  input logic frame_ok_i,
  input logic magic_en_i,
  input logic pme_en_i,
  input logic wake_o,
  input logic hit_w,
  input logic found_w
);
  p_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
  p_after_eof_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(byte_vld_i && eof_i));
  p_frame_ok_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(frame_ok_i));
  p_enables_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(magic_en_i && pme_en_i));
  p_hit_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_w |=> found_w);
  p_sof_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && sof_i) |=> !found_w);
  p_wake_found_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> found_w);
endmodule

bind mpkt_wake_det mpkt_wake_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .byte_vld_i (byte_vld_i),
  .sof_i      (sof_i),
  .eof_i      (eof_i),
  .frame_ok_i (frame_ok_i),
  .magic_en_i (magic_en_i),
  .pme_en_i   (pme_en_i),
  .wake_o     (wake_o),
  .hit_w      (hit_w),
  .found_w    (found_w)
);

// File: tb/mpkt_wake_det_tb_top.sv
`timescale 1ns/1ps
module mpkt_wake_det_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0, sof = 1'b0, eof = 1'b0, ok = 1'b0;
  logic [7:0]  dat = 8'h00;
  logic [47:0] sid = 48'h665544332211;
  logic        men = 1'b1, pen = 1'b1;
  logic        wake;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {bit e; string r;} exp_t;
  exp_t       exp_q[$];
  logic [7:0] fb[$];

  always #2.5 clk = ~clk;

  mpkt_wake_det dut_i (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(vld), .sof_i(sof), .eof_i(eof),
    .byte_i(dat), .frame_ok_i(ok), .station_id_i(sid), .magic_en_i(men),
    .pme_en_i(pen), .wake_o(wake)
  );

  task automatic check(bit act, bit expv, string req);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: wake_o=%0b expected %0b", req, act, expv);
    end
  endtask

  task automatic put_sync(int n);
    repeat (n) fb.push_back(8'hFF);
  endtask

  task automatic put_id(int reps);
    for (int r = 0; r < reps; r++)
      for (int k = 0; k < 6; k++) fb.push_back(sid[8*k +: 8]);
  endtask

  task automatic put_fill(int n);
    for (int i = 0; i < n; i++) fb.push_back(8'h20 + 8'(i));
  endtask

  task automatic send(bit okv, bit me, bit pe, bit expv, string req, int gap = 0);
    exp_q.push_back('{expv, req});
    for (int i = 0; i < fb.size(); i++) begin
      if (gap != 0 && (i % gap) == gap - 1) begin
        @(posedge clk); #1; vld = 1'b0; sof = 1'b0; eof = 1'b0;
      end
      @(posedge clk); #1;
      vld = 1'b1; dat = fb[i];
      sof = (i == 0); eof = (i == fb.size() - 1);
      ok  = (i == fb.size() - 1) ? okv : 1'b0;
      men = me; pen = pe;
    end
    @(posedge clk); #1;
    vld = 1'b0; sof = 1'b0; eof = 1'b0; ok = 1'b0;
    repeat (4) @(posedge clk);
    fb.delete();
  endtask

  // monitor / scoreboard
  initial begin
    bit   seen;
    exp_t x;
    forever begin
      @(posedge clk);
      seen = rst_n && vld && eof;
      @(negedge clk);
      if (seen) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL scoreboard: frame end with no expected item, wake_o=%0b expected none", wake);
        end else begin
          x = exp_q.pop_front();
          check(wake, x.e, x.r);
          if (x.e) begin
            @(negedge clk);
            check(wake, 1'b0, "R7 pulse width");
          end
        end
      end else if (rst_n && wake) begin
        n_chk++; n_fail++;
        $display("FAIL R7: spurious wake_o=1 expected 0");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(wake, 1'b0, "R9 in reset");
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(wake, 1'b0, "R9 after reset");

    put_fill(10); put_sync(6); put_id(16); put_fill(4);
    send(1, 1, 1, 1, "R2 basic mid-frame");
    put_sync(6); put_fill(7); put_id(16); put_fill(3);
    send(1, 1, 1, 1, "R3 filler after sync");
    put_fill(5); put_sync(5); put_id(16); put_fill(3);
    send(1, 1, 1, 0, "R1 five-byte sync");
    put_sync(3); fb.push_back(8'h00); put_sync(3); put_id(16); put_fill(2);
    send(1, 1, 1, 0, "R1 broken sync");
    put_sync(6); put_id(15); put_fill(6);
    send(1, 1, 1, 0, "R11 fifteen reps");
    put_sync(6); put_id(16); put_fill(2);
    send(0, 1, 1, 0, "R5 bad frame");
    put_sync(6); put_id(16); put_fill(2);
    send(1, 0, 1, 0, "R6 magic enable off");
    put_sync(6); put_id(16); put_fill(2);
    send(1, 1, 0, 0, "R6 pme enable off");
    put_fill(3); put_sync(6); put_id(16);
    send(1, 1, 1, 1, "R10 ends on eof byte");
    put_sync(6); put_id(16); put_fill(2);
    send(1, 1, 1, 1, "R8 first frame");
    put_fill(30);
    send(1, 1, 1, 0, "R8 next frame no carry");
    put_sync(6); put_id(5);
    for (int k = 0; k < 3; k++) fb.push_back(sid[8*k +: 8]);
    put_id(16); put_fill(2);
    send(1, 1, 1, 1, "R4 broken run resumes");
    put_sync(9); put_id(16); put_fill(1);
    send(1, 1, 1, 1, "R4 long sync run");
    put_sync(6);
    for (int r = 0; r < 16; r++)
      for (int k = 5; k >= 0; k--) fb.push_back(sid[8*k +: 8]);
    put_fill(2);
    send(1, 1, 1, 0, "R2 reversed byte order");
    put_fill(4); put_sync(6); put_id(16); put_fill(4);
    send(1, 1, 1, 1, "R3 idle gaps", 7);

    repeat (10) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule